// File: doc/BRIEF.md
# Parallel Bit Error Counter

This block measures the error performance of a parallel receive path. On every clock where the valid strobe is high it compares a received word against the word a reference pattern source says should have arrived. Each bus line is judged on its own, so one word can add anywhere from zero up to the full word width to the error total. A second counter adds the word width to a running total of compared bits. Bit-error rate is then the error total divided by the bit total.

Both totals saturate and never wrap, so a long soak test cannot report a falsely low rate. A sticky flag records that at least one mismatch has been seen. A synchronous clear restarts the measurement. The defaults are a 10-bit word, a 32-bit error total and a 48-bit bit total. The 48-bit total covers well beyond 10^12 compared bits, which is the range needed to resolve rates near one error in a trillion. The block takes one word per cycle of a single receive clock, for example a doubled byte clock at 106.25 MHz.

Top module: `parallel_bit_error_counter`

## Requirements
- R1: While reset is asserted and right after it, `err_count` and `bit_count` are 0 and `err_sticky` is 0.
- R2: On a clock edge where `valid` is 1 and `clr` is 0, `err_count` grows by the number of bit positions in which `rx_word` and `exp_word` differ.
- R3: On such an edge `bit_count` grows by WORD_W, which is 10 by default.
- R4: On an edge where `valid` and `clr` are both 0, no output changes, whatever the data inputs carry.
- R5: `err_count` stops at 2^ERR_W-1 and never wraps. A word that would pass that value leaves it at the maximum.
- R6: `bit_count` stops at 2^BIT_W-1 and never wraps.
- R7: `err_sticky` goes to 1 on the edge after the first valid word that has any mismatch. It stays 1 through later matching words and idle cycles until a clear.
- R8: An edge with `clr` = 1 sets both counters and `err_sticky` to 0. This holds even when `valid` is 1 with mismatching data in the same cycle.
- R9: A valid word equal to its expected word leaves `err_count` and `err_sticky` unchanged and still advances `bit_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous restart of the measurement |
| valid | input | 1 | Marks a cycle whose words are to be compared |
| rx_word | input | WORD_W | Word taken from the receiver |
| exp_word | input | WORD_W | Word from the reference pattern |
| err_count | output | ERR_W | Saturating total of mismatched bits |
| bit_count | output | BIT_W | Saturating total of compared bits |
| err_sticky | output | 1 | Set once any mismatch has been seen |

## Verification
The bench keeps the 10-bit word and shrinks the error total to 6 bits and the bit total to 8 bits. With those widths both saturation points come within a few dozen words: about seven all-wrong words fill the error total and 26 words fill the bit total. The run therefore covers the cap on each counter and the words after it, as well as clearing out of saturation. It uses the chained population-count variant, so the other variant is built only with the default parameters.

// File: rtl/pbec_pkg.sv
`timescale 1ns/1ps
package pbec_pkg;
   // Structure choice for the per-word mismatch counter
   typedef enum logic {
      POP_LOOP  = 1'b0,   // behavioural summation loop
      POP_CHAIN = 1'b1    // explicit ripple chain of partial sums
   } pop_impl_e;
endpackage

// File: rtl/pbec_popcount.sv
`timescale 1ns/1ps
module pbec_popcount
   import pbec_pkg::*;
#(
   parameter int        WORD_W = 10,
   parameter pop_impl_e IMPL   = POP_LOOP,
   localparam int       CW     = $clog2(WORD_W + 1)
) (
   input  logic [WORD_W-1:0] diff,
   output logic [CW-1:0]     ones
);
   generate
      if (WORD_W < 1) begin : g_bad_width
         $error("pbec_popcount: WORD_W must be at least 1");
      end

      if (IMPL == POP_CHAIN) begin : g_chain
         logic [CW-1:0] part [WORD_W+1];
         assign part[0] = '0;
         for (genvar g = 0; g < WORD_W; g++) begin : g_stage
            assign part[g+1] = part[g] + CW'(diff[g]);
         end
         assign ones = part[WORD_W];
      end else begin : g_loop
         always_comb begin
            ones = '0;
            for (int i = 0; i < WORD_W; i++) begin
               ones = ones + CW'(diff[i]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pbec_sat_counter.sv
`timescale 1ns/1ps
module pbec_sat_counter #(
   parameter int CNT_W = 32,
   parameter int INC_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [INC_W-1:0] inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (INC_W > CNT_W) begin : g_bad_inc
         $error("pbec_sat_counter: INC_W must not exceed CNT_W");
      end
   endgenerate

   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      sum = {1'b0, count} + (CNT_W+1)'(inc);
      nxt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (en) begin
         count <= nxt;
      end
   end

   // R5 / R6: without a clear the total never moves downward (no wrap)
   p_monotonic_r5_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> count >= $past(count));

   // R5 / R6: once at the ceiling the total stays there until cleared
   p_sat_hold_r5_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX && !clr) |=> count == CNT_MAX);
endmodule

// File: rtl/parallel_bit_error_counter.sv
`timescale 1ns/1ps
module parallel_bit_error_counter
   import pbec_pkg::*;
#(
   parameter int        WORD_W   = 10,
   parameter int        ERR_W    = 32,
   parameter int        BIT_W    = 48,
   parameter pop_impl_e POP_IMPL = POP_LOOP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              valid,
   input  logic [WORD_W-1:0] rx_word,
   input  logic [WORD_W-1:0] exp_word,
   output logic [ERR_W-1:0]  err_count,
   output logic [BIT_W-1:0]  bit_count,
   output logic              err_sticky
);
   localparam int CW = $clog2(WORD_W + 1);
   localparam logic [CW-1:0]    WORD_INC = CW'(WORD_W);
   localparam logic [BIT_W-1:0] BIT_MAX  = {BIT_W{1'b1}};

   generate
      if (ERR_W < CW) begin : g_bad_err_w
         $error("parallel_bit_error_counter: ERR_W too small for one word");
      end
      if (BIT_W < CW) begin : g_bad_bit_w
         $error("parallel_bit_error_counter: BIT_W too small for one word");
      end
   endgenerate

   logic [WORD_W-1:0] diff;
   logic [CW-1:0]     miss_cnt;
   logic              any_miss;

   assign diff     = rx_word ^ exp_word;
   assign any_miss = |diff;

   pbec_popcount #(
      .WORD_W (WORD_W),
      .IMPL   (POP_IMPL)
   ) u_pop (
      .diff (diff),
      .ones (miss_cnt)
   );

   pbec_sat_counter #(
      .CNT_W (ERR_W),
      .INC_W (CW)
   ) u_err_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (valid),
      .inc   (miss_cnt),
      .count (err_count)
   );

   pbec_sat_counter #(
      .CNT_W (BIT_W),
      .INC_W (CW)
   ) u_bit_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .en    (valid),
      .inc   (WORD_INC),
      .count (bit_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_sticky <= 1'b0;
      end else if (clr) begin
         err_sticky <= 1'b0;
      end else if (valid && any_miss) begin
         err_sticky <= 1'b1;
      end
   end

   // R4: idle cycles freeze all results
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !clr) |=> ($stable(err_count) && $stable(bit_count) && $stable(err_sticky)));

   // R3: below the ceiling every valid word adds exactly one word of bits
   p_bit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !clr && bit_count <= BIT_MAX - BIT_W'(WORD_W))
      |=> bit_count == $past(bit_count) + BIT_W'(WORD_W));

   // R7: the flag never drops without a clear
   p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (err_sticky && !clr) |=> err_sticky);

   // R8: clear wins over everything else
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (err_count == '0 && bit_count == '0 && !err_sticky));

   // R9: a clean word adds no errors
   p_clean_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !clr && rx_word == exp_word) |=> err_count == $past(err_count));
endmodule

// File: tb/parallel_bit_error_counter_tb_top.sv
`timescale 1ns/1ps
module parallel_bit_error_counter_tb_top;
   import pbec_pkg::*;

   localparam int WORD_W = 10;
   localparam int ERR_W  = 6;
   localparam int BIT_W  = 8;
   localparam longint ERR_CAP = (64'd1 << ERR_W) - 1;
   localparam longint BIT_CAP = (64'd1 << BIT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clr = 1'b0;
   logic              valid = 1'b0;
   logic [WORD_W-1:0] rx_word = '0;
   logic [WORD_W-1:0] exp_word = '0;
   logic [ERR_W-1:0]  err_count;
   logic [BIT_W-1:0]  bit_count;
   logic              err_sticky;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   longint m_err = 0;
   longint m_bits = 0;
   bit     m_flag = 0;

   always #2 clk = ~clk;   // 250 MHz

   parallel_bit_error_counter #(
      .WORD_W   (WORD_W),
      .ERR_W    (ERR_W),
      .BIT_W    (BIT_W),
      .POP_IMPL (POP_CHAIN)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .valid      (valid),
      .rx_word    (rx_word),
      .exp_word   (exp_word),
      .err_count  (err_count),
      .bit_count  (bit_count),
      .err_sticky (err_sticky)
   );

   task automatic compare(input string tag);
      checks++;
      if (longint'(err_count) != m_err) begin
         failures++;
         $display("FAIL %s err_count actual=%0d expected=%0d", tag, err_count, m_err);
      end
      checks++;
      if (longint'(bit_count) != m_bits) begin
         failures++;
         $display("FAIL %s bit_count actual=%0d expected=%0d", tag, bit_count, m_bits);
      end
      checks++;
      if (err_sticky != m_flag) begin
         failures++;
         $display("FAIL %s err_sticky actual=%0d expected=%0d", tag, err_sticky, m_flag);
      end
   endtask

   // Check the outcome of the previous edge, then drive the next word and
   // advance the reference model to the state the coming edge should give.
   task automatic step(input string tag, input bit c, input bit v,
                       input logic [WORD_W-1:0] rx, input logic [WORD_W-1:0] ex);
      @(negedge clk);
      compare(tag);
      clr = c; valid = v; rx_word = rx; exp_word = ex;
      if (c) begin
         m_err = 0; m_bits = 0; m_flag = 0;
      end else if (v) begin
         m_err  = m_err + $countones(rx ^ ex);
         if (m_err > ERR_CAP) m_err = ERR_CAP;
         m_bits = m_bits + WORD_W;
         if (m_bits > BIT_CAP) m_bits = BIT_CAP;
         if (rx != ex) m_flag = 1;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 in reset");
      rst_n = 1'b1;
      // R1: state right after reset
      step("R1", 0, 0, '0, '0);
      // R9 / R3: clean words advance only the bit total
      step("R9", 0, 1, 10'h155, 10'h155);
      step("R3", 0, 1, 10'h2AA, 10'h2AA);
      step("R9", 0, 1, 10'h3FF, 10'h3FF);
      // R2 / R7: single and multi-bit mismatches
      step("R2", 0, 1, 10'h001, 10'h000);
      step("R7", 0, 1, 10'h0F0, 10'h00F);
      // R4: idle cycles with garbage data
      step("R4", 0, 0, 10'h3FF, 10'h000);
      step("R4", 0, 0, 10'h123, 10'h321);
      // R7: flag holds through clean words
      step("R7", 0, 1, 10'h0AA, 10'h0AA);
      // R8: clear beats a valid mismatched word
      step("R8", 1, 1, 10'h3FF, 10'h000);
      step("R8", 0, 0, '0, '0);
      // R5: all-wrong words drive the error total into its ceiling
      for (int i = 0; i < 9; i++) step("R5", 0, 1, 10'h3FF, 10'h000);
      // R6: keep going until the bit total hits its ceiling
      for (int i = 0; i < 22; i++) step("R6", 0, 1, 10'h155, 10'h0AA);
      step("R6", 0, 0, '0, '0);
      // R8: clear out of saturation
      step("R8", 1, 0, '0, '0);
      // R2: walking ones and random words
      for (int i = 0; i < WORD_W; i++) step("R2", 0, 1, 10'(1 << i), 10'h000);
      for (int i = 0; i < 12; i++) begin
         logic [WORD_W-1:0] a;
         logic [WORD_W-1:0] b;
         a = WORD_W'($urandom);
         b = (i % 3 == 0) ? a : WORD_W'($urandom);
         step("R2", 0, (i % 4 != 3), a, b);
      end
      step("R5", 0, 0, '0, '0);
      step("R5", 0, 0, '0, '0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule